// File: doc/BRIEF.md
# Packet Buffer Pool State Manager

This block keeps the books for a pool of sixteen 2048-byte packet buffers that serve one direction of traffic through an inline encryption device. It does not move packet data; it decides which buffer the receive DMA may fill next, remembers each buffer's stage, length and error flag, and presents buffers to the stage that owns them next. Two instances are used: one for frames arriving on the trusted (red) side, which may carry administration packets, and one for the untrusted (black) side, which cannot.

Each buffer is in exactly one of six lists: free, receiving, awaiting inspection, control, crypt and transmit. A completed frame goes to inspection. The classifier's verdict then sends it to control, to crypt or straight to transmit. Crypt results go to transmit. Buffers leaving control or transmit return to the free list. Stage events (request, completion, acknowledge) are latched as pending. A fixed polling loop visits one list per cycle in the order grant, completion, inspect, control, crypt, transmit, and serves that list's pending event if one is waiting. The loop's states are SL_GRANT, SL_DONE, SL_INSP, SL_CTRL, SL_CRYPT and SL_XMIT. Each one always advances to the next, and SL_XMIT wraps to SL_GRANT. Every list is a FIFO, so buffers are served oldest first.

Top module: `pktbuf_pool`

## Requirements
- R1: After reset every buffer reads state FREE (code 0), length 0 and error 0, drop_cnt is 0, and no stage valid is high.
- R2: A one-cycle rx_req pulse yields a one-cycle rx_gnt carrying the id of the oldest free buffer; freed buffers join the tail of the free list. The granted buffer reads state RECV (code 1) and its error flag is cleared.
- R3: A completion (rx_done) with rx_done_ok=1 and length at most 2048 moves the buffer to INSP (code 2) and records the length. Buffers are offered on insp_id in completion order.
- R4: An inspection acknowledge routes the head buffer by insp_verdict: 2'b00 and 2'b11 to XMIT (code 5), 2'b01 to CRYPT (code 4), 2'b10 to CTRL (code 3) on the red-side instance.
- R5: Acknowledging control returns the buffer to FREE, acknowledging crypt moves it to XMIT, and acknowledging transmit returns it to FREE. Each list is served oldest first.
- R6: A completion with rx_done_ok=0 (checksum failure) frees the buffer, sets its error flag and records the length.
- R7: A completion with length above 2048 frees the buffer, sets its error flag and records the length as 2048.
- R8: A request while no buffer is free produces a one-cycle rx_refuse instead of a grant and adds one to drop_cnt.
- R9: With RED_SIDE=0, ctl_valid never rises and verdict 2'b10 routes the buffer to XMIT.
- R10: A completion naming a buffer not in RECV has no effect on any buffer or list.
- R11: The lists are served by a fixed six-slot polling loop. At most one buffer changes state per cycle.
- R12: The free, inspect, control, crypt and transmit lists together with the RECV buffers always account for all sixteen buffers, and each list's length matches the number of buffers in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_req | input | 1 | Receive DMA asks for a buffer (pulse) |
| rx_gnt | output | 1 | Buffer granted (one cycle) |
| rx_gnt_id | output | 4 | Granted buffer id |
| rx_refuse | output | 1 | Request refused, pool empty (one cycle) |
| drop_cnt | output | 8 | Refused-frame count, wraps |
| rx_done | input | 1 | Receive completion (pulse) |
| rx_done_id | input | 4 | Buffer that completed |
| rx_done_len | input | 12 | Frame length in bytes |
| rx_done_ok | input | 1 | Frame checksum good |
| insp_valid | output | 1 | A buffer awaits inspection |
| insp_id | output | 4 | Oldest buffer awaiting inspection |
| insp_ack | input | 1 | Inspection done (pulse) |
| insp_verdict | input | 2 | 00 forward, 01 crypt, 10 control, 11 forward |
| ctl_valid | output | 1 | A buffer awaits control handling |
| ctl_id | output | 4 | Oldest control buffer |
| ctl_ack | input | 1 | Configuration applied (pulse) |
| cry_valid | output | 1 | A buffer awaits crypt |
| cry_id | output | 4 | Oldest crypt buffer |
| cry_ack | input | 1 | Crypt finished (pulse) |
| tx_valid | output | 1 | A buffer awaits transmit |
| tx_id | output | 4 | Oldest transmit buffer |
| tx_ack | input | 1 | Transmit finished (pulse) |
| q_id | input | 4 | Buffer selected for status read |
| q_state | output | 3 | State code of q_id |
| q_len | output | 12 | Recorded length of q_id |
| q_err | output | 1 | Error flag of q_id |

## Verification
The hardest situation to reach is pool exhaustion after the free list has been reordered by mixed return paths. By then the grant order is no longer the reset order, and a refusal has to appear exactly when the sixteenth outstanding buffer is held. The stimulus first sends buffers through crypt, control, forward, bad-checksum and oversize paths, and releases them in a deliberate order. The scoreboard's expected grant queue is built from that release order. The bench then requests sixteen more buffers and two beyond, so a refusal is expected only after the reordered list is used up.

// File: rtl/pbp_pkg.sv
`timescale 1ns/1ps
package pbp_pkg;
    typedef enum logic [2:0] {
        BS_FREE  = 3'd0,
        BS_RECV  = 3'd1,
        BS_INSP  = 3'd2,
        BS_CTRL  = 3'd3,
        BS_CRYPT = 3'd4,
        BS_XMIT  = 3'd5
    } buf_st_e;

    typedef enum logic [2:0] {
        SL_GRANT = 3'd0,
        SL_DONE  = 3'd1,
        SL_INSP  = 3'd2,
        SL_CTRL  = 3'd3,
        SL_CRYPT = 3'd4,
        SL_XMIT  = 3'd5
    } slot_e;

    localparam int NUM_SLOTS = 6;

    localparam logic [1:0] VD_FWD   = 2'b00;
    localparam logic [1:0] VD_CRYPT = 2'b01;
    localparam logic [1:0] VD_CTRL  = 2'b10;
endpackage

// File: rtl/pbp_idq.sv
`timescale 1ns/1ps
module pbp_idq #(
    parameter int DEPTH     = 16,
    parameter int ID_W      = 4,
    parameter bit INIT_FULL = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [ID_W-1:0]              push_id,
    input  logic                         pop,
    output logic [ID_W-1:0]              head,
    output logic                         empty,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [ID_W-1:0]  mem [DEPTH];
    logic [PTR_W-1:0] rd_p;
    logic [PTR_W-1:0] wr_p;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_p  <= '0;
            wr_p  <= '0;
            count <= INIT_FULL ? CNT_W'(DEPTH) : '0;
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= INIT_FULL ? ID_W'(i) : '0;
        end else begin
            if (push) begin
                mem[wr_p] <= push_id;
                wr_p      <= step(wr_p);
            end
            if (pop)
                rd_p <= step(rd_p);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head  = mem[rd_p];
    assign empty = (count == '0);
endmodule

// File: rtl/pbp_table.sv
`timescale 1ns/1ps
module pbp_table
    import pbp_pkg::*;
#(
    parameter int NUM_BUFS = 16,
    parameter int ID_W     = 4,
    parameter int LEN_W    = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [ID_W-1:0]           wid,
    input  logic [2:0]                wst,
    input  logic                      len_we,
    input  logic [LEN_W-1:0]          wlen,
    input  logic                      err_set,
    input  logic                      err_clr,
    input  logic [ID_W-1:0]           q_id,
    output logic [2:0]                q_state,
    output logic [LEN_W-1:0]          q_len,
    output logic                      q_err,
    output logic [NUM_BUFS-1:0][2:0]  st_vec
);
    logic [NUM_BUFS-1:0][LEN_W-1:0] len_a;
    logic [NUM_BUFS-1:0]            err_a;

    for (genvar g = 0; g < NUM_BUFS; g++) begin : g_buf
        logic             hit;
        logic [2:0]       st;
        logic [LEN_W-1:0] len;
        logic             err;

        assign hit = (wid == ID_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st  <= BS_FREE;
                len <= '0;
                err <= 1'b0;
            end else begin
                if (we && hit)
                    st <= wst;
                if (len_we && hit)
                    len <= wlen;
                if (err_set && hit)
                    err <= 1'b1;
                else if (err_clr && hit)
                    err <= 1'b0;
            end
        end

        assign st_vec[g] = st;
        assign len_a[g]  = len;
        assign err_a[g]  = err;
    end

    assign q_state = st_vec[q_id];
    assign q_len   = len_a[q_id];
    assign q_err   = err_a[q_id];
endmodule

// File: rtl/pbp_poller.sv
`timescale 1ns/1ps
module pbp_poller
    import pbp_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SLOTS-1:0] pend,
    output logic [NUM_SLOTS-1:0] svc,
    output slot_e                slot
);
    slot_e slot_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot <= SL_GRANT;
        else        slot <= slot_nx;
    end

    always_comb begin
        svc     = '0;
        slot_nx = SL_GRANT;
        unique case (slot)
            SL_GRANT: begin slot_nx = SL_DONE;  svc[SL_GRANT] = pend[SL_GRANT]; end
            SL_DONE:  begin slot_nx = SL_INSP;  svc[SL_DONE]  = pend[SL_DONE];  end
            SL_INSP:  begin slot_nx = SL_CTRL;  svc[SL_INSP]  = pend[SL_INSP];  end
            SL_CTRL:  begin slot_nx = SL_CRYPT; svc[SL_CTRL]  = pend[SL_CTRL];  end
            SL_CRYPT: begin slot_nx = SL_XMIT;  svc[SL_CRYPT] = pend[SL_CRYPT]; end
            SL_XMIT:  begin slot_nx = SL_GRANT; svc[SL_XMIT]  = pend[SL_XMIT];  end
            default:  begin slot_nx = SL_GRANT; end
        endcase
    end
endmodule

// File: rtl/pktbuf_pool.sv
`timescale 1ns/1ps
module pktbuf_pool
    import pbp_pkg::*;
#(
    parameter int NUM_BUFS  = 16,
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 12,
    parameter int DROP_W    = 8,
    parameter bit RED_SIDE  = 1'b1,
    parameter int ID_W      = $clog2(NUM_BUFS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_req,
    output logic              rx_gnt,
    output logic [ID_W-1:0]   rx_gnt_id,
    output logic              rx_refuse,
    output logic [DROP_W-1:0] drop_cnt,
    input  logic              rx_done,
    input  logic [ID_W-1:0]   rx_done_id,
    input  logic [LEN_W-1:0]  rx_done_len,
    input  logic              rx_done_ok,
    output logic              insp_valid,
    output logic [ID_W-1:0]   insp_id,
    input  logic              insp_ack,
    input  logic [1:0]        insp_verdict,
    output logic              ctl_valid,
    output logic [ID_W-1:0]   ctl_id,
    input  logic              ctl_ack,
    output logic              cry_valid,
    output logic [ID_W-1:0]   cry_id,
    input  logic              cry_ack,
    output logic              tx_valid,
    output logic [ID_W-1:0]   tx_id,
    input  logic              tx_ack,
    input  logic [ID_W-1:0]   q_id,
    output logic [2:0]        q_state,
    output logic [LEN_W-1:0]  q_len,
    output logic              q_err
);
    localparam int CNT_W = $clog2(NUM_BUFS+1);
    localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(BUF_BYTES);

    // pending stage events, latched until the poller visits the slot
    logic             pend_rx, pend_done, pend_insp, pend_ctl, pend_cry, pend_tx;
    logic [ID_W-1:0]  done_id_q;
    logic [LEN_W-1:0] done_len_q;
    logic             done_ok_q;
    logic [1:0]       verd_q;

    logic [NUM_SLOTS-1:0] svc;
    slot_e                slot;

    // list queues
    logic free_push, free_pop, free_empty;
    logic insp_push, insp_pop, insp_empty;
    logic ctl_push, ctl_pop, ctl_empty;
    logic cry_push, cry_pop, cry_empty;
    logic xq_push, xq_pop, xq_empty;
    logic [ID_W-1:0] free_pid, xq_pid, free_head;
    logic [CNT_W-1:0] free_cnt, insp_cnt, ctl_cnt, cry_cnt, xq_cnt;

    // table write port
    logic             t_we, t_len_we, t_err_set, t_err_clr;
    logic [ID_W-1:0]  t_id;
    logic [2:0]       t_st;
    logic [LEN_W-1:0] t_len;
    logic [NUM_BUFS-1:0][2:0] st_vec;

    logic gnt_d, refuse_d, too_long;

    pbp_poller u_poll (
        .clk  (clk),
        .rst_n(rst_n),
        .pend ({pend_tx, pend_cry, pend_ctl, pend_insp, pend_done, pend_rx}),
        .svc  (svc),
        .slot (slot)
    );

    pbp_idq #(.DEPTH(NUM_BUFS), .ID_W(ID_W), .INIT_FULL(1'b1)) u_freeq (
        .clk(clk), .rst_n(rst_n), .push(free_push), .push_id(free_pid),
        .pop(free_pop), .head(free_head), .empty(free_empty), .count(free_cnt));

    pbp_idq #(.DEPTH(NUM_BUFS), .ID_W(ID_W), .INIT_FULL(1'b0)) u_inspq (
        .clk(clk), .rst_n(rst_n), .push(insp_push), .push_id(done_id_q),
        .pop(insp_pop), .head(insp_id), .empty(insp_empty), .count(insp_cnt));

    pbp_idq #(.DEPTH(NUM_BUFS), .ID_W(ID_W), .INIT_FULL(1'b0)) u_ctlq (
        .clk(clk), .rst_n(rst_n), .push(ctl_push), .push_id(insp_id),
        .pop(ctl_pop), .head(ctl_id), .empty(ctl_empty), .count(ctl_cnt));

    pbp_idq #(.DEPTH(NUM_BUFS), .ID_W(ID_W), .INIT_FULL(1'b0)) u_cryq (
        .clk(clk), .rst_n(rst_n), .push(cry_push), .push_id(insp_id),
        .pop(cry_pop), .head(cry_id), .empty(cry_empty), .count(cry_cnt));

    pbp_idq #(.DEPTH(NUM_BUFS), .ID_W(ID_W), .INIT_FULL(1'b0)) u_xq (
        .clk(clk), .rst_n(rst_n), .push(xq_push), .push_id(xq_pid),
        .pop(xq_pop), .head(tx_id), .empty(xq_empty), .count(xq_cnt));

    pbp_table #(.NUM_BUFS(NUM_BUFS), .ID_W(ID_W), .LEN_W(LEN_W)) u_tab (
        .clk(clk), .rst_n(rst_n), .we(t_we), .wid(t_id), .wst(t_st),
        .len_we(t_len_we), .wlen(t_len), .err_set(t_err_set), .err_clr(t_err_clr),
        .q_id(q_id), .q_state(q_state), .q_len(q_len), .q_err(q_err), .st_vec(st_vec));

    assign insp_valid = !insp_empty && !pend_insp;
    assign ctl_valid  = !ctl_empty  && !pend_ctl;
    assign cry_valid  = !cry_empty  && !pend_cry;
    assign tx_valid   = !xq_empty   && !pend_tx;
    assign too_long   = (done_len_q > MAX_LEN);

    // pending-event capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_rx <= 1'b0; pend_done <= 1'b0; pend_insp <= 1'b0;
            pend_ctl <= 1'b0; pend_cry <= 1'b0; pend_tx <= 1'b0;
            done_id_q <= '0; done_len_q <= '0; done_ok_q <= 1'b0; verd_q <= '0;
        end else begin
            if (svc[SL_GRANT])          pend_rx <= 1'b0;
            else if (rx_req)            pend_rx <= 1'b1;

            if (svc[SL_DONE])           pend_done <= 1'b0;
            else if (rx_done && !pend_done) begin
                pend_done  <= 1'b1;
                done_id_q  <= rx_done_id;
                done_len_q <= rx_done_len;
                done_ok_q  <= rx_done_ok;
            end

            if (svc[SL_INSP])           pend_insp <= 1'b0;
            else if (insp_ack && insp_valid) begin
                pend_insp <= 1'b1;
                verd_q    <= insp_verdict;
            end

            if (svc[SL_CTRL])           pend_ctl <= 1'b0;
            else if (ctl_ack && ctl_valid) pend_ctl <= 1'b1;

            if (svc[SL_CRYPT])          pend_cry <= 1'b0;
            else if (cry_ack && cry_valid) pend_cry <= 1'b1;

            if (svc[SL_XMIT])           pend_tx <= 1'b0;
            else if (tx_ack && tx_valid) pend_tx <= 1'b1;
        end
    end

    // list moves for the slot being served
    always_comb begin
        free_push = 1'b0; free_pop = 1'b0; free_pid = '0;
        insp_push = 1'b0; insp_pop = 1'b0;
        ctl_push  = 1'b0; ctl_pop  = 1'b0;
        cry_push  = 1'b0; cry_pop  = 1'b0;
        xq_push   = 1'b0; xq_pop   = 1'b0; xq_pid = '0;
        t_we = 1'b0; t_id = '0; t_st = BS_FREE;
        t_len_we = 1'b0; t_len = '0; t_err_set = 1'b0; t_err_clr = 1'b0;
        gnt_d = 1'b0; refuse_d = 1'b0;

        if (svc[SL_GRANT]) begin
            if (!free_empty) begin
                free_pop  = 1'b1;
                t_we      = 1'b1;
                t_id      = free_head;
                t_st      = BS_RECV;
                t_err_clr = 1'b1;
                gnt_d     = 1'b1;
            end else begin
                refuse_d = 1'b1;
            end
        end

        if (svc[SL_DONE] && st_vec[done_id_q] == BS_RECV) begin
            t_we     = 1'b1;
            t_id     = done_id_q;
            t_len_we = 1'b1;
            t_len    = too_long ? MAX_LEN : done_len_q;
            if (done_ok_q && !too_long) begin
                t_st      = BS_INSP;
                insp_push = 1'b1;
            end else begin
                t_st      = BS_FREE;
                t_err_set = 1'b1;
                free_push = 1'b1;
                free_pid  = done_id_q;
            end
        end

        if (svc[SL_INSP]) begin
            insp_pop = 1'b1;
            t_we     = 1'b1;
            t_id     = insp_id;
            if (verd_q == VD_CRYPT) begin
                t_st     = BS_CRYPT;
                cry_push = 1'b1;
            end else if (verd_q == VD_CTRL && RED_SIDE) begin
                t_st     = BS_CTRL;
                ctl_push = 1'b1;
            end else begin
                t_st    = BS_XMIT;
                xq_push = 1'b1;
                xq_pid  = insp_id;
            end
        end

        if (svc[SL_CTRL]) begin
            ctl_pop   = 1'b1;
            t_we      = 1'b1;
            t_id      = ctl_id;
            t_st      = BS_FREE;
            free_push = 1'b1;
            free_pid  = ctl_id;
        end

        if (svc[SL_CRYPT]) begin
            cry_pop = 1'b1;
            t_we    = 1'b1;
            t_id    = cry_id;
            t_st    = BS_XMIT;
            xq_push = 1'b1;
            xq_pid  = cry_id;
        end

        if (svc[SL_XMIT]) begin
            xq_pop    = 1'b1;
            t_we      = 1'b1;
            t_id      = tx_id;
            t_st      = BS_FREE;
            free_push = 1'b1;
            free_pid  = tx_id;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_gnt    <= 1'b0;
            rx_gnt_id <= '0;
            rx_refuse <= 1'b0;
            drop_cnt  <= '0;
        end else begin
            rx_gnt    <= gnt_d;
            rx_refuse <= refuse_d;
            if (gnt_d)    rx_gnt_id <= free_head;
            if (refuse_d) drop_cnt  <= drop_cnt + DROP_W'(1);
        end
    end
endmodule

// File: rtl/pktbuf_pool_chk.sv
`timescale 1ns/1ps
module pktbuf_pool_chk
    import pbp_pkg::*;
#(
    parameter int NUM_BUFS = 16,
    parameter int ID_W     = 4,
    parameter int DROP_W   = 8,
    parameter bit RED_SIDE = 1'b1,
    parameter int CNT_W    = $clog2(NUM_BUFS+1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rx_gnt,
    input logic [ID_W-1:0]          rx_gnt_id,
    input logic                     rx_refuse,
    input logic [DROP_W-1:0]        drop_cnt,
    input logic                     ctl_valid,
    input logic [NUM_BUFS-1:0][2:0] st_vec,
    input logic [CNT_W-1:0]         free_cnt,
    input logic [CNT_W-1:0]         insp_cnt,
    input logic [CNT_W-1:0]         ctl_cnt,
    input logic [CNT_W-1:0]         cry_cnt,
    input logic [CNT_W-1:0]         xq_cnt
);
    logic [NUM_BUFS-1:0][2:0] st_prev;
    logic [NUM_BUFS-1:0]      changed;
    int n_free, n_recv, n_insp, n_ctrl, n_cry, n_xmit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_prev <= '0;
        else        st_prev <= st_vec;
    end

    always_comb begin
        n_free = 0; n_recv = 0; n_insp = 0; n_ctrl = 0; n_cry = 0; n_xmit = 0;
        for (int i = 0; i < NUM_BUFS; i++) begin
            changed[i] = (st_vec[i] != st_prev[i]);
            case (st_vec[i])
                BS_FREE:  n_free++;
                BS_RECV:  n_recv++;
                BS_INSP:  n_insp++;
                BS_CTRL:  n_ctrl++;
                BS_CRYPT: n_cry++;
                default:  n_xmit++;
            endcase
        end
    end

    a_r8_grant_refuse_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_gnt && rx_refuse));

    a_r8_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        rx_refuse |-> drop_cnt == DROP_W'($past(drop_cnt) + DROP_W'(1)));

    a_r2_granted_recv: assert property (@(posedge clk) disable iff (!rst_n)
        rx_gnt |-> st_vec[rx_gnt_id] == BS_RECV);

    a_r9_no_ctrl_black: assert property (@(posedge clk) disable iff (!rst_n)
        !RED_SIDE |-> !ctl_valid);

    a_r11_one_move: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(changed) <= 1);

    a_r12_conserve: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) + int'(insp_cnt) + int'(ctl_cnt) + int'(cry_cnt)
            + int'(xq_cnt) + n_recv == NUM_BUFS);

    a_r12_lists_match: assert property (@(posedge clk) disable iff (!rst_n)
        int'(free_cnt) == n_free && int'(insp_cnt) == n_insp &&
        int'(ctl_cnt) == n_ctrl && int'(cry_cnt) == n_cry && int'(xq_cnt) == n_xmit);
endmodule

bind pktbuf_pool pktbuf_pool_chk #(
    .NUM_BUFS(NUM_BUFS), .ID_W(ID_W), .DROP_W(DROP_W), .RED_SIDE(RED_SIDE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_gnt(rx_gnt), .rx_gnt_id(rx_gnt_id),
    .rx_refuse(rx_refuse), .drop_cnt(drop_cnt), .ctl_valid(ctl_valid),
    .st_vec(st_vec), .free_cnt(free_cnt), .insp_cnt(insp_cnt),
    .ctl_cnt(ctl_cnt), .cry_cnt(cry_cnt), .xq_cnt(xq_cnt)
);

// File: tb/pktbuf_pool_tb.sv
`timescale 1ns/1ps
module pktbuf_pool_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;   // 50 MHz

    // red-side instance
    logic rx_req = 0, rx_done = 0, rx_done_ok = 0, insp_ack = 0, ctl_ack = 0, cry_ack = 0, tx_ack = 0;
    logic [3:0] rx_done_id = 0, q_id = 0;
    logic [11:0] rx_done_len = 0;
    logic [1:0] insp_verdict = 0;
    logic rx_gnt, rx_refuse, insp_valid, ctl_valid, cry_valid, tx_valid, q_err;
    logic [3:0] rx_gnt_id, insp_id, ctl_id, cry_id, tx_id;
    logic [7:0] drop_cnt;
    logic [2:0] q_state;
    logic [11:0] q_len;

    // black-side instance
    logic b_req = 0, b_done = 0, b_insp_ack = 0, b_tx_ack = 0;
    logic b_gnt, b_refuse, b_insp_valid, b_ctl_valid, b_cry_valid, b_tx_valid, b_q_err;
    logic [3:0] b_gnt_id, b_insp_id, b_ctl_id, b_cry_id, b_tx_id;
    logic [7:0] b_drop;
    logic [2:0] b_q_state;
    logic [11:0] b_q_len;

    pktbuf_pool u_dut (
        .clk(clk), .rst_n(rst_n), .rx_req(rx_req), .rx_gnt(rx_gnt), .rx_gnt_id(rx_gnt_id),
        .rx_refuse(rx_refuse), .drop_cnt(drop_cnt), .rx_done(rx_done), .rx_done_id(rx_done_id),
        .rx_done_len(rx_done_len), .rx_done_ok(rx_done_ok), .insp_valid(insp_valid),
        .insp_id(insp_id), .insp_ack(insp_ack), .insp_verdict(insp_verdict),
        .ctl_valid(ctl_valid), .ctl_id(ctl_id), .ctl_ack(ctl_ack), .cry_valid(cry_valid),
        .cry_id(cry_id), .cry_ack(cry_ack), .tx_valid(tx_valid), .tx_id(tx_id), .tx_ack(tx_ack),
        .q_id(q_id), .q_state(q_state), .q_len(q_len), .q_err(q_err));

    pktbuf_pool #(.RED_SIDE(1'b0)) u_dut_blk (
        .clk(clk), .rst_n(rst_n), .rx_req(b_req), .rx_gnt(b_gnt), .rx_gnt_id(b_gnt_id),
        .rx_refuse(b_refuse), .drop_cnt(b_drop), .rx_done(b_done), .rx_done_id(4'd0),
        .rx_done_len(12'd80), .rx_done_ok(1'b1), .insp_valid(b_insp_valid),
        .insp_id(b_insp_id), .insp_ack(b_insp_ack), .insp_verdict(2'b10),
        .ctl_valid(b_ctl_valid), .ctl_id(b_ctl_id), .ctl_ack(1'b0), .cry_valid(b_cry_valid),
        .cry_id(b_cry_id), .cry_ack(1'b0), .tx_valid(b_tx_valid), .tx_id(b_tx_id),
        .tx_ack(b_tx_ack), .q_id(4'd0), .q_state(b_q_state), .q_len(b_q_len), .q_err(b_q_err));

    int n_chk = 0;
    int n_err = 0;
    int exp_gnt[$];
    bit done_flag = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // scoreboard monitor: every red-side grant must match the expected free-list order (R2)
    always @(negedge clk) begin
        if (rst_n && rx_gnt) begin
            if (exp_gnt.size() == 0) chk("R2", "unexpected grant id", int'(rx_gnt_id), -1);
            else chk("R2", "grant id order", int'(rx_gnt_id), exp_gnt.pop_front());
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic request(input int exp_id, input bit exp_ref, input string req);
        bit got_g = 0, got_r = 0;
        if (!exp_ref) exp_gnt.push_back(exp_id);
        @(negedge clk) rx_req = 1;
        @(negedge clk) rx_req = 0;
        for (int i = 0; i < 12 && !got_g && !got_r; i++) begin
            @(negedge clk);
            got_g = rx_gnt;
            got_r = rx_refuse;
        end
        chk(req, "refuse instead of grant", int'(got_r), int'(exp_ref));
        chk(req, "grant seen", int'(got_g), int'(!exp_ref));
    endtask

    task automatic complete(input int id, input int len, input bit ok);
        @(negedge clk);
        rx_done = 1; rx_done_id = 4'(id); rx_done_len = 12'(len); rx_done_ok = ok;
        @(negedge clk) rx_done = 0;
        tick(8);
    endtask

    task automatic look(input int id, input int st, input string req);
        q_id = 4'(id);
        #1;
        chk(req, $sformatf("state of buffer %0d", id), int'(q_state), st);
    endtask

    task automatic inspect(input int exp_id, input logic [1:0] v, input string req);
        chk(req, "inspect valid", int'(insp_valid), 1);
        chk(req, "inspect head", int'(insp_id), exp_id);
        @(negedge clk) begin insp_ack = 1; insp_verdict = v; end
        @(negedge clk) insp_ack = 0;
        tick(8);
    endtask

    initial begin
        #4ms;
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        tick(3);
        // R1: reset state
        begin
            int bad = 0;
            for (int i = 0; i < 16; i++) begin
                q_id = 4'(i); #1;
                if (q_state != 0 || q_len != 0 || q_err != 0) bad++;
            end
            chk("R1", "buffers not free after reset", bad, 0);
        end
        chk("R1", "drop count", int'(drop_cnt), 0);
        chk("R1", "valids", int'({insp_valid, ctl_valid, cry_valid, tx_valid}), 0);
        rst_n = 1;
        tick(2);

        // R2/R3: three grants and completions
        request(0, 0, "R2"); request(1, 0, "R2"); request(2, 0, "R2");
        look(0, 1, "R2");
        complete(0, 100, 1);
        look(0, 2, "R3");
        chk("R3", "recorded length", int'(q_len), 100);
        complete(1, 64, 1);
        complete(2, 60, 1);

        // R4: routing in completion order
        inspect(0, 2'b01, "R3"); look(0, 4, "R4");
        inspect(1, 2'b10, "R3"); look(1, 3, "R4");
        inspect(2, 2'b00, "R3"); look(2, 5, "R4");
        chk("R4", "inspect list empty", int'(insp_valid), 0);

        // R5: crypt -> transmit, transmit order, control -> free
        chk("R5", "crypt head", int'(cry_id), 0);
        @(negedge clk) cry_ack = 1; @(negedge clk) cry_ack = 0; tick(8);
        look(0, 5, "R5");
        chk("R5", "oldest transmit first", int'(tx_id), 2);
        @(negedge clk) tx_ack = 1; @(negedge clk) tx_ack = 0; tick(8);
        look(2, 0, "R5");
        chk("R5", "control head", int'(ctl_id), 1);
        @(negedge clk) ctl_ack = 1; @(negedge clk) ctl_ack = 0; tick(8);
        look(1, 0, "R5");
        chk("R5", "next transmit", int'(tx_id), 0);
        @(negedge clk) tx_ack = 1; @(negedge clk) tx_ack = 0; tick(8);
        look(0, 0, "R5");
        chk("R5", "transmit list empty", int'(tx_valid), 0);

        // R6: checksum failure
        request(3, 0, "R6");
        complete(3, 100, 0);
        look(3, 0, "R6");
        chk("R6", "error flag", int'(q_err), 1);
        chk("R6", "length", int'(q_len), 100);

        // R7: oversize frame
        request(4, 0, "R7");
        complete(4, 3000, 1);
        look(4, 0, "R7");
        chk("R7", "error flag", int'(q_err), 1);
        chk("R7", "clamped length", int'(q_len), 2048);
        chk("R7", "not offered to inspection", int'(insp_valid), 0);

        // R10: completion for a free buffer is ignored
        complete(5, 200, 1);
        look(5, 0, "R10");
        chk("R10", "length untouched", int'(q_len), 0);
        chk("R10", "nothing to inspect", int'(insp_valid), 0);

        // R8: exhaust the reordered free list, then refusals
        for (int i = 5; i < 16; i++) request(i, 0, "R2");
        request(2, 0, "R2"); request(1, 0, "R2"); request(0, 0, "R2");
        request(3, 0, "R2");
        look(3, 1, "R2");
        chk("R2", "error cleared on regrant", int'(q_err), 0);
        request(4, 0, "R2");
        request(0, 1, "R8");
        chk("R8", "drop count after one refusal", int'(drop_cnt), 1);
        request(0, 1, "R8");
        chk("R8", "drop count after two refusals", int'(drop_cnt), 2);
        chk("R2", "scoreboard drained", exp_gnt.size(), 0);

        // R9: black-side control verdict goes to transmit
        @(negedge clk) b_req = 1; @(negedge clk) b_req = 0; tick(8);
        @(negedge clk) b_done = 1; @(negedge clk) b_done = 0; tick(8);
        chk("R9", "black inspect head", int'(b_insp_id), 0);
        @(negedge clk) b_insp_ack = 1; @(negedge clk) b_insp_ack = 0; tick(8);
        chk("R9", "black state after control verdict", int'(b_q_state), 5);
        chk("R9", "black control valid", int'(b_ctl_valid), 0);
        chk("R9", "black transmit head", int'(b_tx_valid), 1);
        @(negedge clk) b_tx_ack = 1; @(negedge clk) b_tx_ack = 0; tick(8);
        chk("R9", "black buffer freed", int'(b_q_state), 0);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule